// File: doc/BRIEF.md
# Token Bucket Traffic Regulator

This block holds a single token bucket and uses it to keep a stream of byte-counted packets within a burst-and-rate envelope. Every clock cycle the bucket gains a fixed-point increment of tokens, with eight fractional bits, until it reaches its programmed depth. Any credit above that depth is lost. A packet request carries its length in bytes. It conforms only when the whole integer token count covers that length. A conforming packet then spends one token per byte in the cycle it is taken.

A configuration bit picks one of two modes. In policing mode, a request is taken as soon as the output slot can hold it. A request that lacks tokens goes out at once with a drop flag and spends nothing. In shaping mode, the input stays not-ready while the offered packet lacks tokens. The packet therefore waits at the head of the upstream queue and leaves as soon as the bucket covers it. Both sides use valid/ready handshakes, and one output register separates them. Over any window of t cycles the conforming bytes never exceed the depth plus t times the rate.

Top module: `tkn_regulator`

## Requirements
- R1: In the first cycle after reset, the bucket holds exactly `depth_i` tokens. A packet of length `depth_i` offered in that cycle conforms, and the output register starts empty.
- R2: Each clock cycle adds `rate_i` to the bucket. `rate_i` is unsigned fixed point with eight fractional bits, so 0x0100 adds one token. Fractional credit carries over from cycle to cycle.
- R3: The bucket never holds more than `depth_i` tokens. Credit that would exceed that level is discarded, so a packet longer than `depth_i` never conforms.
- R4: A request taken in a cycle conforms exactly when `in_len` is no greater than the integer part of the bucket in that cycle, counted before that cycle's refill. Its output entry carries `out_drop` = 0 if it conforms and 1 otherwise.
- R5: A conforming packet spends `in_len` tokens in the cycle it is taken. A non-conforming packet spends none.
- R6: In policing mode (`shape_i` = 0), `in_ready` is high whenever the output slot is empty or is being read in that cycle, whatever the token count.
- R7: In shaping mode (`shape_i` = 1), `in_ready` is low while the offered length is not covered by tokens. Shaping mode therefore never emits `out_drop` = 1.
- R8: A packet taken at a clock edge appears on `out_valid`/`out_len`/`out_drop` right after that edge. It stays there unchanged until a cycle with `out_ready` high.
- R9: While the output slot is full and `out_ready` is low, `in_ready` is low in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads a full bucket |
| shape_i | input | 1 | 1 selects shaping mode, 0 selects policing mode |
| rate_i | input | RATE_W | Tokens added per cycle, eight fractional bits |
| depth_i | input | CNT_W | Bucket depth in tokens (bytes) |
| in_valid | input | 1 | Packet request offered |
| in_ready | output | 1 | Request can be taken this cycle |
| in_len | input | LEN_W | Packet length in bytes |
| out_valid | output | 1 | Output entry present |
| out_ready | input | 1 | Downstream takes the output entry |
| out_len | output | LEN_W | Length of the output packet |
| out_drop | output | 1 | Output packet failed the bucket check |

## Verification
Both modes are swept across four refill rates, from a quarter token per cycle to three per cycle, and two depths. Packet lengths step through the range from one byte to past the depth, and the offers and downstream stalls follow patterns that are not aligned with each other. A directed opening covers four cases:
- a full-depth packet offered straight after reset, which shows whether the bucket starts full;
- a one-byte packet just behind it, which separates "drop spends nothing" from "drop spends tokens";
- a long idle run followed by packets of length depth+1 and depth, which exposes a missing cap;
- a block of cycles with the output stalled, which shows whether backpressure reaches `in_ready`.

Fractional rates catch a refill that rounds away the carried fraction.

// File: rtl/tkn_regulator.sv
module tkn_regulator #(
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shape_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [CNT_W-1:0]  depth_i,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LEN_W-1:0]  in_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_drop
);
  localparam int BW = CNT_W + FRAC_W;

  logic [BW-1:0] bkt_q;
  logic [BW:0]   cap, spend, sum;
  logic          conform, slot_ok, take;

  assign cap     = {1'b0, depth_i, {FRAC_W{1'b0}}};
  assign conform = CNT_W'(in_len) <= bkt_q[BW-1:FRAC_W];
  assign slot_ok = !out_valid || out_ready;
  assign in_ready = slot_ok && (!shape_i || conform);
  assign take    = in_valid && in_ready;
  assign spend   = (take && conform) ? (BW+1)'({in_len, {FRAC_W{1'b0}}}) : '0;
  assign sum     = {1'b0, bkt_q} - spend + (BW+1)'(rate_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bkt_q     <= cap[BW-1:0];
      out_valid <= 1'b0;
      out_len   <= '0;
      out_drop  <= 1'b0;
    end else begin
      bkt_q <= (sum > cap) ? cap[BW-1:0] : sum[BW-1:0];
      if (take) begin
        out_valid <= 1'b1;
        out_len   <= in_len;
        out_drop  <= !conform;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tkn_regulator_chk.sv
module tkn_regulator_chk #(
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    shape_i,
  input logic [CNT_W-1:0]        depth_i,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [LEN_W-1:0]        in_len,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LEN_W-1:0]        out_len,
  input logic                    out_drop,
  input logic [CNT_W+FRAC_W-1:0] bkt_q
);
  // R1
  full_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) && $stable(depth_i) |-> bkt_q == {depth_i, {FRAC_W{1'b0}}} && !out_valid);

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(depth_i) |-> bkt_q <= {depth_i, {FRAC_W{1'b0}}});

  // R4
  short_credit_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (CNT_W'(in_len) > bkt_q[CNT_W+FRAC_W-1:FRAC_W]) |=> out_valid && out_drop);

  // R6
  police_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shape_i && (!out_valid || out_ready) |-> in_ready);

  // R7
  shape_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shape_i && in_valid && in_ready |=> !out_drop);

  // R8
  hold_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_len) && $stable(out_drop));

  // R9
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

bind tkn_regulator tkn_regulator_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .shape_i(shape_i), .depth_i(depth_i),
  .in_valid(in_valid), .in_ready(in_ready), .in_len(in_len),
  .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len),
  .out_drop(out_drop), .bkt_q(bkt_q)
);

// File: tb/tkn_regulator_bench.sv
`timescale 1ns/1ps
module tkn_regulator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shape_i = 1'b0;
  logic [15:0] rate_i = '0;
  logic [15:0] depth_i = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_len = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [11:0] out_len;
  logic        out_drop;

  always #4 clk = ~clk;

  tkn_regulator u_tkn_regulator (
    .clk(clk), .rst_n(rst_n), .shape_i(shape_i), .rate_i(rate_i), .depth_i(depth_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_len(in_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len), .out_drop(out_drop)
  );

  int    n_chk = 0, n_bad = 0;
  bit    done = 0;
  longint m_bkt;
  bit    m_ov, m_drop;
  int    m_len;
  string m_tag;

  task automatic check(input longint act, input longint exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic do_reset(input bit s, input int rate, input int depth);
    @(negedge clk);
    rst_n = 0; shape_i = s; rate_i = 16'(rate); depth_i = 16'(depth);
    in_valid = 0; out_ready = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_bkt = longint'(depth) * 256; m_ov = 0; m_drop = 0; m_len = 0; m_tag = "R1";
    #1 check(out_valid, 0, "R1 reset out_valid");
  endtask

  task automatic step(input bit v, input int len, input bit ordy, input string tag);
    bit conf, slot, e_rdy, take;
    longint nb;
    @(negedge clk);
    in_valid = v; in_len = 12'(len); out_ready = ordy;
    #1;
    conf  = longint'(len) * 256 <= m_bkt;
    slot  = !m_ov || ordy;
    e_rdy = slot && (!shape_i || conf);
    check(in_ready, e_rdy, !slot ? "R9 in_ready" : (shape_i ? "R7 in_ready" : "R6 in_ready"));
    check(out_valid, m_ov, "R8 out_valid");
    if (m_ov) begin
      check(out_len, m_len, {m_tag, " out_len"});
      check(out_drop, m_drop, {m_tag, " out_drop"});
    end
    take = v && e_rdy;
    nb = m_bkt - ((take && conf) ? longint'(len) * 256 : 0) + longint'(rate_i);
    if (nb > longint'(depth_i) * 256) nb = longint'(depth_i) * 256;
    if (take) begin
      m_ov = 1; m_len = len; m_drop = !conf; m_tag = tag;
    end else if (ordy) m_ov = 0;
    m_bkt = nb;
  endtask

  initial begin
    int rates[4] = '{64, 256, 384, 768};
    int depths[2] = '{20, 48};
    for (int s = 0; s < 2; s++)
      for (int ri = 0; ri < 4; ri++)
        for (int di = 0; di < 2; di++) begin
          do_reset(s[0], rates[ri], depths[di]);
          step(1, depths[di], 1, "R1");
          step(1, 1, 1, "R5");
          step(1, 1, 1, "R2");
          step(1, 2, 1, "R2");
          for (int i = 0; i < 100; i++) step(0, 0, 1, "R3");
          step(1, depths[di] + 1, 1, "R3");
          step(1, depths[di], 1, "R3");
          for (int i = 0; i < 150; i++)
            step(i % 5 != 4, ((i * 37 + ri * 11) % (depths[di] + 4)) + 1, i % 4 != 3, "R4");
          for (int i = 0; i < 30; i++)
            step(1, (i % 7) + 1, i >= 6, "R8");
        end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule